// File: doc/BRIEF.md
# Commutation-Period Capture Timer

This block times how long a brushless motor's rotor takes to move between hall-sensor positions. A 16-bit counter runs in plain up-count mode. Its rate comes from a prescaled system clock.

An upstream position detector sends one strobe each time the filtered hall state changes. A selectable grouping of 1, 3 or 6 strobes forms one measurement. That is 60, 180 or 360 electrical degrees. At the end of each group the running count is copied into the capture register and the counter restarts from zero. An interrupt flag can be raised at the same moment. Software turns the captured period into a speed.

Top module: `commutation_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count`, `capture` and `irq` are all zero.
- R2: `cfg_psc` codes 000, 001, 010, 011, 100 and 101 make `count` advance by one every 1, 4, 16, 64, 256 and 1024 system clocks, when counting on a single edge. Codes 110 and 111 hold the count.
- R3: `cfg_edge` 00 (rising) and 01 (falling) give the same rate. 10 or 11 (both edges) doubles the rate for codes 001 to 101. With code 000 the count advances once per clock whatever the edge code.
- R4: `count` saturates at 0xFFFF and stays there until a clear.
- R5: With `cfg_clr` = 110, every `pos_change` strobe loads `capture` with the value `count` held before that edge, and `count` reads zero after the edge.
- R6: With `cfg_clr` = 101 only every third strobe captures and clears. With 100 only every sixth does. The other strobes leave `capture` and `count` undisturbed.
- R7: With `cfg_clr` = 000 (or any code other than 100, 101 or 110), every strobe captures but `count` is never cleared.
- R8: A capture sets `irq` the following cycle when `irq_en` is 1. With `irq_en` at 0 a capture leaves `irq` low.
- R9: A one-cycle `irq_ack` pulse clears `irq`. If a capture and an acknowledge fall on the same cycle, the flag stays set.
- R10: A change of `cfg_clr` restarts the strobe grouping, so the next capture comes after a full group of strobes under the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_change | input | 1 | One-cycle strobe per qualified hall position change |
| cfg_psc | input | 3 | Count clock divider code |
| cfg_edge | input | 2 | Count edge select: 00 rising, 01 falling, 1x both |
| cfg_clr | input | 3 | Clear grouping: 110 every change, 101 every third, 100 every sixth, else never |
| irq_en | input | 1 | Interrupt mask, 1 lets a capture set the flag |
| irq_ack | input | 1 | Write-one-to-clear pulse for the flag |
| count | output | 16 | Live counter value |
| capture | output | 16 | Last captured period |
| irq | output | 1 | Capture interrupt flag |

## Verification
Some rules are checked by the assertions on every clock cycle:
- the counter never moves by more than one step except at a clear;
- the counter stays pinned at 0xFFFF once it gets there;
- every clearing group end loads the pre-clear value and zeroes the counter;
- the flag rises only after an unmasked capture.

Other behaviour can only be shown by the bench's scenarios:
- the absolute divider rates for each prescaler and edge code;
- the 3- and 6-strobe groupings;
- the restart of the grouping when the clear code changes;
- the set-over-acknowledge priority.

// File: rtl/commutation_timer.sv
module commutation_timer #(
  parameter int CW = 16,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pos_change,
  input  logic [2:0]    cfg_psc,
  input  logic [1:0]    cfg_edge,
  input  logic [2:0]    cfg_clr,
  input  logic          irq_en,
  input  logic          irq_ack,
  output logic [CW-1:0] count,
  output logic [CW-1:0] capture,
  output logic          irq
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] lo_mask;
  logic [3:0]    kbit;
  logic          tick;
  logic [2:0]    clr_q;
  logic [2:0]    grp;
  logic [2:0]    grp_len;
  logic          clr_en;
  logic          cfg_moved;
  logic          evt;

  always_comb begin
    kbit    = {cfg_psc, 1'b0} - 4'd1;
    lo_mask = (DW'(1) << kbit) - DW'(1);
    case (cfg_psc)
      3'd0: tick = 1'b1;
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5:
        tick = ((div_cnt & lo_mask) == lo_mask) &&
               (cfg_edge[1] || (cfg_edge[0] ? div_cnt[kbit] : !div_cnt[kbit]));
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    clr_en = 1'b1;
    case (cfg_clr)
      3'b110:  grp_len = 3'd1;
      3'b101:  grp_len = 3'd3;
      3'b100:  grp_len = 3'd6;
      default: begin grp_len = 3'd1; clr_en = 1'b0; end
    endcase
  end

  assign cfg_moved = (cfg_clr != clr_q);
  assign evt = pos_change && !cfg_moved && (grp == grp_len - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      clr_q   <= '0;
      grp     <= '0;
      count   <= '0;
      capture <= '0;
      irq     <= 1'b0;
    end else begin
      div_cnt <= div_cnt + DW'(1);
      clr_q   <= cfg_clr;
      if (cfg_moved)      grp <= '0;
      else if (evt)       grp <= '0;
      else if (pos_change) grp <= grp + 3'd1;
      if (evt) capture <= count;
      if (evt && clr_en)              count <= '0;
      else if (tick && count != CMAX) count <= count + CW'(1);
      if (evt && irq_en) irq <= 1'b1;
      else if (irq_ack)  irq <= 1'b0;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> (count == $past(count) || count == $past(count) + CW'(1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !evt) |=> count == CMAX);

  p_capture_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr_en) |=> (count == '0 && capture == $past(count)));

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr_en) |=> capture == $past(count));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && irq_en) |=> irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq ##1 irq |-> $past(evt && irq_en));

  p_irq_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !evt) |=> !irq);
endmodule

// File: tb/commutation_timer_bench.sv
module commutation_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pos_change = 1'b0;
  logic [2:0]  cfg_psc = 3'd0;
  logic [1:0]  cfg_edge = 2'd0;
  logic [2:0]  cfg_clr = 3'b000;
  logic        irq_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic [15:0] count, capture;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  commutation_timer u_commutation_timer (
    .clk(clk), .rst_n(rst_n), .pos_change(pos_change), .cfg_psc(cfg_psc),
    .cfg_edge(cfg_edge), .cfg_clr(cfg_clr), .irq_en(irq_en), .irq_ack(irq_ack),
    .count(count), .capture(capture), .irq(irq));

  localparam int NV = 12;
  localparam int VPSC [NV] = '{0, 1, 1, 1, 2, 2, 3, 3, 4, 5, 5, 0};
  localparam int VEDG [NV] = '{0, 0, 1, 2, 0, 3, 1, 2, 0, 0, 2, 3};
  localparam int VCYC [NV] = '{40, 40, 40, 40, 64, 64, 128, 128, 512, 2048, 2048, 20};
  localparam int VDLT [NV] = '{40, 10, 10, 20, 4, 8, 2, 4, 2, 2, 4, 20};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    pos_change = 1'b1;
    @(negedge clk);
    pos_change = 1'b0;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c0, cap0;
    cyc(3);
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after release", count, 1);
    chk("R1 capture after release", capture, 0);

    for (int v = 0; v < NV; v++) begin
      cfg_psc  = 3'(VPSC[v]);
      cfg_edge = 2'(VEDG[v]);
      c0 = count;
      cyc(VCYC[v]);
      chk((VEDG[v] >= 2) ? "R3 rate" : "R2 rate", count - c0, VDLT[v]);
    end
    cfg_psc = 3'd6;
    c0 = count;
    cyc(30);
    chk("R2 hold code", count, c0);

    cfg_psc = 3'd0;
    cfg_clr = 3'b110;
    irq_en  = 1'b1;
    cyc(5);
    c0 = count;
    strobe();
    chk("R5 capture", capture, c0);
    chk("R5 cleared", count, 0);
    chk("R8 irq set", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 ack clears", irq, 0);
    cyc(7);
    c0 = count;
    pos_change = 1'b1;
    irq_ack = 1'b1;
    @(negedge clk);
    pos_change = 1'b0;
    irq_ack = 1'b0;
    chk("R9 set wins", irq, 1);
    chk("R5 second capture", capture, c0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;

    irq_en = 1'b0;
    cyc(4);
    strobe();
    chk("R8 masked", irq, 0);

    cfg_clr = 3'b101;
    irq_en = 1'b1;
    cyc(3);
    cap0 = capture;
    strobe(); cyc(4);
    strobe(); cyc(4);
    chk("R6 third: no capture yet", capture, cap0);
    chk("R6 third: no irq yet", irq, 0);
    chk("R6 third: no clear", (count > 8) ? 1 : 0, 1);
    c0 = count;
    strobe();
    chk("R6 third capture", capture, c0);
    chk("R6 third clear", count, 0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

    cfg_clr = 3'b100;
    cyc(3);
    cap0 = capture;
    for (int s = 0; s < 5; s++) begin strobe(); cyc(2); end
    chk("R6 sixth: none before", capture, cap0);
    c0 = count;
    strobe();
    chk("R6 sixth capture", capture, c0);
    chk("R6 sixth clear", count, 0);

    strobe(); cyc(2);
    strobe(); cyc(2);
    cfg_clr = 3'b101;
    cyc(3);
    cap0 = capture;
    strobe(); cyc(2);
    chk("R10 regroup first", capture, cap0);
    strobe(); cyc(2);
    chk("R10 regroup second", capture, cap0);
    c0 = count;
    strobe();
    chk("R10 regroup third", capture, c0);

    cfg_clr = 3'b000;
    cyc(5);
    c0 = count;
    strobe();
    chk("R7 capture", capture, c0);
    chk("R7 no clear", count, c0 + 1);
    cyc(3);
    c0 = count;
    strobe();
    chk("R7 capture again", capture, c0);

    cyc(65600);
    chk("R4 saturated", count, 16'hFFFF);
    cyc(20);
    chk("R4 stays", count, 16'hFFFF);
    cfg_clr = 3'b110;
    cyc(3);
    strobe();
    chk("R4 stalled period", capture, 16'hFFFF);
    chk("R5 restart", count, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule